// File: doc/BRIEF.md
# Vector-Programmed FIFO Word Serializer

This block sits between a 32-bit transmit FIFO and a protocol shifter. It converts each FIFO entry into a stream of single bits. The bits are not sent in a fixed shift order. Four programmable extraction vectors choose the bits and their order. Each vector names a start bit index, a walking direction, a run length of one to eight bits, and a flag that marks it as the last vector for the word. Software sets up the vectors so that several short protocol words packed in one entry (for example four 7-bit words, one per byte lane) are sent correctly. It can also send one wide word that spans byte lanes.

The FIFO head is read through a valid/ready pair, and the shifter takes bits through a valid/ready pair of its own. A word starts only when the block is idle and the FIFO offers data. At that moment the two configuration registers are captured, so reprogramming during a word affects only later words. The FIFO entry is popped in the same cycle that the shifter accepts the word's final bit.

Top module: `vser_fifo_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bit_valid` and `fifo_pop` are low.
- R2: Vector n occupies bits [10*(n mod 2)+9 : 10*(n mod 2)] of `cfg_pair0` for n = 0 and 1, and of `cfg_pair1` for n = 2 and 3. Within a vector, bits [9:5] are the start index, bit 4 selects the direction (1 = descending index, 0 = ascending), bits [3:1] hold the run length minus one, and bit 0 is the stop flag.
- R3: A vector emits length-field+1 bits of the FIFO word. The first is the bit at the start index, and each later bit steps the index by one in the programmed direction.
- R4: Vectors are used in order 0, 1, 2, 3. The word ends after the last bit of the first vector whose stop flag is 1. Later vectors emit nothing for that word.
- R5: If vectors 0 to 3 all have the stop flag clear, the word ends after vector 3.
- R6: Bit index arithmetic wraps modulo 32: stepping down from 0 gives 31, and stepping up from 31 gives 0.
- R7: `fifo_pop` is high for exactly the cycle in which the word's final bit is accepted (`bit_valid` and `bit_ready` both high). In the next cycle `bit_valid` is low.
- R8: While `bit_valid` is high and `bit_ready` is low, `bit_valid` stays high and `bit_out` stays unchanged in the next cycle.
- R9: An idle block with `fifo_valid` low emits no bits. An idle block that sees `fifo_valid` high presents the first bit of that word in the following cycle.
- R10: The configuration registers are captured only on the cycle a word starts. Changes made during a word take effect from the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pair0 | input | 20 | Vectors 0 (low half) and 1 (high half) |
| cfg_pair1 | input | 20 | Vectors 2 (low half) and 3 (high half) |
| fifo_data | input | 32 | FIFO head entry, held until popped |
| fifo_valid | input | 1 | FIFO head entry present |
| fifo_pop | output | 1 | Remove the FIFO head entry |
| bit_out | output | 1 | Serial data bit |
| bit_valid | output | 1 | `bit_out` is valid |
| bit_ready | input | 1 | Shifter accepts the bit this cycle |

## Verification
The bench builds the block with its default 32-bit word width. This makes the full 5-bit start field meaningful and lets index wrap-around occur at both ends of the word. At this width, a four-vector configuration without a stop flag sends a complete 32-bit word, and the two-entries-per-word and single-wide-word packings are both expressible. A behavioural model expands each word into its expected bit list, using the configuration captured when that word began. This lets backpressure, FIFO gaps and reprogramming in the middle of a word all be checked against the same queue.

// File: rtl/vser_pkg.sv
package vser_pkg;
   localparam int VEC_W       = 10;
   localparam int NUM_VEC     = 4;
   localparam int VEC_PER_REG = 2;
   localparam int REG_W       = VEC_W * VEC_PER_REG;
   localparam int START_W     = 5;
   localparam int RUN_W       = 3;

   typedef struct packed {
      logic [START_W-1:0] start;
      logic               desc;
      logic [RUN_W-1:0]   len_m1;
      logic               stop;
   } vec_t;
endpackage

// File: rtl/vser_vec_bank.sv
module vser_vec_bank
   import vser_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [REG_W-1:0]         cfg_pair0,
   input  logic [REG_W-1:0]         cfg_pair1,
   output vec_t [NUM_VEC-1:0]       vecs
);
   localparam int FLAT_W = REG_W * 2;

   logic [FLAT_W-1:0] flat;
   assign flat = {cfg_pair1, cfg_pair0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vecs <= '0;
      end else if (load) begin
         for (int n = 0; n < NUM_VEC; n++) begin
            vecs[n] <= vec_t'(flat[n*VEC_W +: VEC_W]);
         end
      end
   end
endmodule

// File: rtl/vser_seq.sv
module vser_seq
   import vser_pkg::*;
#(
   parameter int N_VEC  = NUM_VEC,
   parameter int STEP_W = RUN_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fifo_valid,
   input  logic                      bit_ready,
   input  logic                      cur_stop,
   input  logic [STEP_W-1:0]         cur_len_m1,
   output logic                      active,
   output logic [$clog2(N_VEC)-1:0]  vsel,
   output logic [STEP_W-1:0]         step,
   output logic                      load,
   output logic                      word_done
);
   localparam int VSEL_W = $clog2(N_VEC);
   localparam logic [VSEL_W-1:0] LAST_VSEL = VSEL_W'(N_VEC - 1);

   logic accept, run_end, vec_end;

   assign load      = !active && fifo_valid;
   assign accept    = active && bit_ready;
   assign run_end   = (step == cur_len_m1);
   assign vec_end   = cur_stop || (vsel == LAST_VSEL);
   assign word_done = accept && run_end && vec_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         vsel   <= '0;
         step   <= '0;
      end else if (load) begin
         active <= 1'b1;
         vsel   <= '0;
         step   <= '0;
      end else if (accept) begin
         if (!run_end) begin
            step <= step + 1'b1;
         end else if (vec_end) begin
            active <= 1'b0;
            vsel   <= '0;
            step   <= '0;
         end else begin
            vsel <= vsel + 1'b1;
            step <= '0;
         end
      end
   end
endmodule

// File: rtl/vser_bit_pick.sv
module vser_bit_pick
   import vser_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]  word,
   input  logic [START_W-1:0] start,
   input  logic               desc,
   input  logic [RUN_W-1:0]   step,
   output logic               bit_o
);
   localparam int IDX_W = $clog2(WORD_W);

   logic [IDX_W-1:0] base, idx;

   generate
      if (IDX_W >= START_W) begin : g_full
         assign base = IDX_W'(start);
      end else begin : g_trunc
         assign base = start[IDX_W-1:0];
      end
   endgenerate

   // Power-of-two width: natural overflow of the index gives the wrap.
   assign idx   = desc ? (base - IDX_W'(step)) : (base + IDX_W'(step));
   assign bit_o = word[idx];
endmodule

// File: rtl/vser_fifo_serializer.sv
module vser_fifo_serializer
   import vser_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  cfg_pair0,
   input  logic [REG_W-1:0]  cfg_pair1,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_valid,
   output logic              fifo_pop,
   output logic              bit_out,
   output logic              bit_valid,
   input  logic              bit_ready
);
   localparam int VSEL_W = $clog2(NUM_VEC);

   generate
      if (WORD_W > 32 || WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
         $error("vser_fifo_serializer: WORD_W must be a power of two from 2 to 32");
      end
      if (NUM_VEC != 2 * VEC_PER_REG) begin : g_bad_count
         $error("vser_fifo_serializer: two configuration registers hold all vectors");
      end
   endgenerate

   vec_t [NUM_VEC-1:0] vecs;
   vec_t               cur;
   logic               active, load, word_done;
   logic [VSEL_W-1:0]  vsel;
   logic [RUN_W-1:0]   step;

   vser_vec_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .cfg_pair0 (cfg_pair0),
      .cfg_pair1 (cfg_pair1),
      .vecs      (vecs)
   );

   assign cur = vecs[vsel];

   vser_seq #(.N_VEC(NUM_VEC), .STEP_W(RUN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_valid (fifo_valid),
      .bit_ready  (bit_ready),
      .cur_stop   (cur.stop),
      .cur_len_m1 (cur.len_m1),
      .active     (active),
      .vsel       (vsel),
      .step       (step),
      .load       (load),
      .word_done  (word_done)
   );

   vser_bit_pick #(.WORD_W(WORD_W)) u_pick (
      .word  (fifo_data),
      .start (cur.start),
      .desc  (cur.desc),
      .step  (step),
      .bit_o (bit_out)
   );

   assign bit_valid = active;
   assign fifo_pop  = word_done;
endmodule

// File: rtl/vser_fifo_serializer_chk.sv
module vser_fifo_serializer_chk (
   input logic clk,
   input logic rst_n,
   input logic fifo_valid,
   input logic fifo_pop,
   input logic bit_out,
   input logic bit_valid,
   input logic bit_ready
);
   p_pop_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (bit_valid && bit_ready && fifo_valid));

   p_gap_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !bit_valid);

   p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !bit_ready) |=> bit_valid);

   p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !bit_ready) |=> $stable(bit_out));

   p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !fifo_valid) |=> !bit_valid);

   p_start_on_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && fifo_valid) |=> bit_valid);
endmodule

bind vser_fifo_serializer vser_fifo_serializer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_valid (fifo_valid),
   .fifo_pop   (fifo_pop),
   .bit_out    (bit_out),
   .bit_valid  (bit_valid),
   .bit_ready  (bit_ready)
);

// File: tb/sim_vser_fifo_serializer.sv
module sim_vser_fifo_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] cfg_pair0 = '0, cfg_pair1 = '0;
   logic [31:0] fifo_data = '0;
   logic        fifo_valid = 1'b0;
   logic        fifo_pop, bit_out, bit_valid;
   logic        bit_ready = 1'b0;

   always #10 clk = ~clk;

   vser_fifo_serializer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_pair0(cfg_pair0), .cfg_pair1(cfg_pair1),
      .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_pop(fifo_pop),
      .bit_out(bit_out), .bit_valid(bit_valid), .bit_ready(bit_ready)
   );

   int          applied = 0, miscompares = 0;
   string       cur_req = "R1";
   logic [31:0] fq[$];
   int          expq[$];
   bit          m_loaded = 0;
   logic [19:0] nxt0 = '0, nxt1 = '0;
   bit          nxt_rst = 0;
   logic [15:0] lfsr = 16'hACE1;
   int          dut_bits = 0, dut_word_bits = -1;

   function automatic logic [9:0] mkvec(int start, bit desc, int len, bit stop);
      return {start[4:0], desc, len[2:0], stop};
   endfunction

   function automatic void expand(logic [39:0] cfg, logic [31:0] w);
      bit done = 0;
      for (int v = 0; v < 4 && !done; v++) begin
         logic [9:0] f = cfg[v*10 +: 10];
         for (int k = 0; k <= int'(f[3:1]); k++) begin
            int idx = f[4] ? int'(f[9:5]) - k : int'(f[9:5]) + k;
            expq.push_back(int'(w[idx & 31]));
         end
         if (f[0]) done = 1;
      end
   endfunction

   task automatic check(string req, int act, int exp, string what);
      applied++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic cyc(bit rdy);
      @(negedge clk);
      rst_n      = nxt_rst;
      cfg_pair0  = nxt0;
      cfg_pair1  = nxt1;
      bit_ready  = rdy;
      fifo_valid = fq.size() > 0;
      fifo_data  = fifo_valid ? fq[0] : 32'h0;
      #1;
      check(cur_req, int'(bit_valid), int'(m_loaded), "bit_valid");
      check(cur_req, int'(fifo_pop), int'(m_loaded && rdy && expq.size() == 1), "fifo_pop");
      if (m_loaded) check(cur_req, int'(bit_out), expq[0], "bit_out");
      if (bit_valid && rdy) dut_bits++;
      if (fifo_pop) begin dut_word_bits = dut_bits; dut_bits = 0; end
      if (!rst_n) return;
      if (!m_loaded) begin
         if (fifo_valid) begin
            expand({cfg_pair1, cfg_pair0}, fifo_data);
            m_loaded = 1;
         end
      end else if (rdy) begin
         void'(expq.pop_front());
         if (expq.size() == 0) begin
            m_loaded = 0;
            void'(fq.pop_front());
         end
      end
   endtask

   task automatic drain(bit random_rdy);
      int guard = 0;
      while ((fq.size() > 0 || m_loaded) && guard < 5000) begin
         cyc(random_rdy ? rnd() : 1'b1);
         guard++;
      end
   endtask

   initial begin
      #(20 * 150000);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

   initial begin
      // R1: reset holds outputs low, even with data offered
      cur_req = "R1";
      fq.push_back(32'h1234_5678);
      for (int i = 0; i < 3; i++) cyc(1'b1);
      nxt_rst = 1;
      fq.delete();
      cyc(1'b1);
      cyc(1'b1);

      // R2 R3 R4: four 7-bit words, MSB first, stop on vector 3
      cur_req = "R2 R3 R4";
      nxt0 = {mkvec(14, 1, 6, 0), mkvec(6, 1, 6, 0)};
      nxt1 = {mkvec(30, 1, 6, 1), mkvec(22, 1, 6, 0)};
      cyc(1'b0);
      fq.push_back(32'hDEAD_BEEF); fq.push_back(32'h0F0F_A5C3); fq.push_back(32'h8000_0001);
      drain(0);
      check("R4", dut_word_bits, 28, "bits per word");

      // R8: backpressure from the shifter
      cur_req = "R8";
      fq.push_back(32'h1357_9BDF); fq.push_back(32'hF00D_CAFE);
      fq.push_back(32'h6666_9999); fq.push_back(32'h0123_4567);
      drain(1);

      // R5-style wide word: 23 bits, vector 3 ignored (R4)
      cur_req = "R4";
      nxt0 = {mkvec(14, 1, 7, 0), mkvec(22, 1, 7, 0)};
      nxt1 = {mkvec(31, 0, 7, 0), mkvec(6, 1, 6, 1)};
      cyc(1'b0);
      fq.push_back(32'h007F_FF55); fq.push_back(32'hFFAB_CDEF);
      drain(0);
      check("R4", dut_word_bits, 23, "bits per wide word");

      // R5: no stop flag anywhere, ascending full word
      cur_req = "R5";
      nxt0 = {mkvec(8, 0, 7, 0), mkvec(0, 0, 7, 0)};
      nxt1 = {mkvec(24, 0, 7, 0), mkvec(16, 0, 7, 0)};
      cyc(1'b0);
      fq.push_back(32'hC001_D00D); fq.push_back(32'h5A5A_0FF0);
      drain(1);
      check("R5", dut_word_bits, 32, "bits per word");

      // R6: index wrap in both directions
      cur_req = "R6";
      nxt0 = {mkvec(29, 0, 5, 1), mkvec(2, 1, 7, 0)};
      nxt1 = '0;
      cyc(1'b0);
      fq.push_back(32'hE000_0005); fq.push_back(32'h9000_0003);
      drain(0);
      check("R6", dut_word_bits, 14, "bits per wrap word");

      // R9: empty FIFO produces nothing; gaps between words
      cur_req = "R9";
      for (int i = 0; i < 5; i++) cyc(1'b1);
      fq.push_back(32'hA0A0_0B0B);
      drain(0);
      for (int i = 0; i < 3; i++) cyc(1'b1);
      fq.push_back(32'h0B0B_A0A0);
      drain(1);

      // R7 R10: reprogram during a word; only the next word sees it
      cur_req = "R7 R10";
      nxt0 = {mkvec(8, 0, 7, 0), mkvec(0, 0, 7, 0)};
      nxt1 = {mkvec(24, 0, 7, 1), mkvec(16, 0, 7, 0)};
      cyc(1'b0);
      fq.push_back(32'h1111_2222); fq.push_back(32'h3333_4444);
      for (int i = 0; i < 4; i++) cyc(1'b1);
      nxt0 = {mkvec(14, 1, 7, 0), mkvec(22, 1, 7, 0)};
      nxt1 = {mkvec(0, 0, 0, 0), mkvec(6, 1, 6, 1)};
      drain(0);
      check("R10", dut_word_bits, 23, "bits of word after reprogram");

      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end
endmodule